// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and checks the even parity bit for a 32-bit multiplexed address/data bus that also carries a 4-bit command/byte-enable field. The block can act as the bus initiator or as the target. The transaction controller around it supplies three things each clock: the current role, the address-phase and data-phase flags, and the transfer direction. The unit uses them to decide whether this side drives AD or receives it.

In a cycle where this side drives AD, the unit computes parity over AD and C/BE. It puts that parity on the parity line in the following clock, together with a parity enable. In a cycle where this side receives AD, it saves the parity of what it sampled. On the next clock it compares the saved parity with the incoming parity line. A mismatch raises a registered error pulse one clock after that.

Top module: `busparity_unit`

## Requirements
- R1: The parity bit is even over all 36 bits of AD[31:0] and C/BE[3:0]: the XOR of those bits with par_o is zero.
- R2: par_o and par_oe_o describe the bus cycle one clock earlier. While par_oe_o is low, par_o is 0.
- R3: With role_init_i=1 (initiator), ad_oe_o is 1 in address-phase cycles and in data-phase cycles with wr_i=1. It is 0 otherwise, including read data phases.
- R4: With role_init_i=0 (target), ad_oe_o is 1 only in data-phase cycles with wr_i=0.
- R5: par_oe_o equals the value ad_oe_o had in the previous cycle. It falls exactly one clock after the block stops driving AD.
- R6: Some cycles are checked cycles: initiator read data phases, and target address or write data phases. Take a checked cycle N. perr_o is 1 in cycle N+2 exactly when par_i sampled in cycle N+1 differs from the even parity of AD and C/BE sampled in cycle N.
- R7: par_i has no effect when the previous cycle was not a checked cycle, that is, an idle or driving cycle. perr_o then stays 0.
- R8: A synchronous active-high reset clears par_o, par_oe_o, perr_o and the saved check state.
- R9: Parity covers every byte lane whatever the byte enables are. C/BE bit 0 belongs to AD[7:0] and bit 3 to AD[31:24], and a C/BE value of 4'b0000 is hashed like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| role_init_i | input | 1 | 1 = initiator, 0 = target |
| addr_ph_i | input | 1 | Current cycle is an address phase |
| data_ph_i | input | 1 | Current cycle is a data phase |
| wr_i | input | 1 | 1 = write transfer, 0 = read transfer |
| ad_i | input | 32 | Address/data value on the bus this cycle |
| cbe_i | input | 4 | Command or byte-enable value this cycle |
| par_i | input | 1 | Sampled incoming parity line |
| par_o | output | 1 | Parity to drive, for the previous cycle |
| par_oe_o | output | 1 | Parity line output enable |
| ad_oe_o | output | 1 | AD output enable for the current cycle |
| perr_o | output | 1 | Registered parity-error pulse |

## Verification
The bench switches the role and direction between consecutive cycles. A design that drives parity in the same cycle as the data, or keeps the enable up one clock too long, then shows a wrong par_o or par_oe_o. Checked cycles alternate correct and flipped par_i, so a check that is off by one clock, or that uses the current AD instead of the saved one, misreports. The bench also drives wrong parity after idle and driving cycles, where a checker that ignores the window raises a false error. Patterns with all byte enables off and with only one lane set catch a generator that masks disabled lanes.

// File: rtl/busparity_pkg.sv
package busparity_pkg;

    typedef struct packed {
        logic par;      // parity to drive this cycle
        logic par_oe;   // parity line enable
        logic chk;      // previous cycle was a checked cycle
        logic sav_par;  // parity of the saved received bus value
        logic perr;     // registered parity error
    } bp_state_t;

    localparam bp_state_t BP_RESET = '{par: 1'b0, par_oe: 1'b0, chk: 1'b0,
                                       sav_par: 1'b0, perr: 1'b0};

endpackage

// File: rtl/busparity_tree.sv
module busparity_tree #(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic [AD_W-1:0]  ad,
    input  logic [CBE_W-1:0] cbe,
    output logic             par
);
    localparam int LANE_W = AD_W / CBE_W;

    logic [CBE_W-1:0] lane_par;

    // one partial XOR per byte lane, folding in that lane's enable bit
    for (genvar g = 0; g < CBE_W; g++) begin : g_lane
        assign lane_par[g] = (^ad[g*LANE_W +: LANE_W]) ^ cbe[g];
    end

    assign par = ^lane_par;
endmodule

// File: rtl/busparity_dir.sv
module busparity_dir (
    input  logic role_init,
    input  logic addr_ph,
    input  logic data_ph,
    input  logic wr,
    output logic drive,
    output logic recv
);
    logic init_drive;
    logic tgt_drive;
    logic init_recv;
    logic tgt_recv;

    always_comb begin
        init_drive = addr_ph || (data_ph && wr);
        init_recv  = !addr_ph && data_ph && !wr;
        tgt_drive  = !addr_ph && data_ph && !wr;
        tgt_recv   = addr_ph || (data_ph && wr);
        drive      = role_init ? init_drive : tgt_drive;
        recv       = role_init ? init_recv  : tgt_recv;
    end
endmodule

// File: rtl/busparity_unit.sv
module busparity_unit
    import busparity_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             role_init_i,
    input  logic             addr_ph_i,
    input  logic             data_ph_i,
    input  logic             wr_i,
    input  logic [AD_W-1:0]  ad_i,
    input  logic [CBE_W-1:0] cbe_i,
    input  logic             par_i,
    output logic             par_o,
    output logic             par_oe_o,
    output logic             ad_oe_o,
    output logic             perr_o
);
    bp_state_t st_d;
    bp_state_t st_q;
    logic      drive;
    logic      recv;
    logic      bus_par;

    busparity_dir u_dir (
        .role_init (role_init_i),
        .addr_ph   (addr_ph_i),
        .data_ph   (data_ph_i),
        .wr        (wr_i),
        .drive     (drive),
        .recv      (recv)
    );

    busparity_tree #(.AD_W(AD_W), .CBE_W(CBE_W)) u_tree (
        .ad  (ad_i),
        .cbe (cbe_i),
        .par (bus_par)
    );

    always_comb begin
        st_d         = st_q;
        st_d.par     = drive ? bus_par : 1'b0;
        st_d.par_oe  = drive;
        st_d.chk     = recv;
        st_d.sav_par = recv ? bus_par : 1'b0;
        // incoming parity for the saved cycle arrives now
        st_d.perr    = st_q.chk && (st_q.sav_par != par_i);
        if (rst_i) begin
            st_d = BP_RESET;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign par_o    = st_q.par;
    assign par_oe_o = st_q.par_oe;
    assign ad_oe_o  = drive;
    assign perr_o   = st_q.perr;
endmodule

// File: rtl/busparity_chk.sv
module busparity_chk #(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             addr_ph_i,
    input logic             data_ph_i,
    input logic [AD_W-1:0]  ad_i,
    input logic [CBE_W-1:0] cbe_i,
    input logic             ad_oe_o,
    input logic             par_o,
    input logic             par_oe_o,
    input logic             perr_o
);
    // R5
    par_oe_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ad_oe_o |=> par_oe_o);

    // R5
    par_oe_drop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !ad_oe_o |=> !par_oe_o);

    // R1
    par_even_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ad_oe_o |=> (((^$past(ad_i)) ^ (^$past(cbe_i)) ^ par_o) == 1'b0));

    // R2
    par_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !par_oe_o |-> !par_o);

    // R3
    drive_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ad_oe_o |-> (addr_ph_i || data_ph_i));

    // R7
    perr_window_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        perr_o |-> ($past(addr_ph_i || data_ph_i, 2) && !$past(ad_oe_o, 2)));

    // R8
    reset_clear_chk: assert property (@(posedge clk_i)
        rst_i |=> (!par_oe_o && !perr_o && !par_o));
endmodule

bind busparity_unit busparity_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .addr_ph_i (addr_ph_i),
    .data_ph_i (data_ph_i),
    .ad_i      (ad_i),
    .cbe_i     (cbe_i),
    .ad_oe_o   (ad_oe_o),
    .par_o     (par_o),
    .par_oe_o  (par_oe_o),
    .perr_o    (perr_o)
);

// File: tb/busparity_unit_test.sv
module busparity_unit_test;
    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        rst, role, aph, dph, wr, par_in;
    logic [31:0] ad;
    logic [3:0]  cbe;
    logic        par_o, par_oe_o, ad_oe_o, perr_o;

    int n_run  = 0;
    int n_fail = 0;

    typedef struct {
        bit    oe;
        bit    par;
        bit    perr;
        string tag;
    } exp_t;

    exp_t q[$];

    // bench model state
    bit pend_chk = 0;
    bit pend_par = 0;
    bit last_par = 0;
    bit done     = 0;

    always #(PER/2) clk = ~clk;

    busparity_unit uut (
        .clk_i(clk), .rst_i(rst), .role_init_i(role), .addr_ph_i(aph),
        .data_ph_i(dph), .wr_i(wr), .ad_i(ad), .cbe_i(cbe), .par_i(par_in),
        .par_o(par_o), .par_oe_o(par_oe_o), .ad_oe_o(ad_oe_o), .perr_o(perr_o)
    );

    function automatic bit even_par(input logic [31:0] a, input logic [3:0] c);
        bit p = 0;
        for (int i = 0; i < 32; i++) p ^= a[i];
        for (int i = 0; i < 4; i++) p ^= c[i];
        return p;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: apply one bus cycle, predict outputs after the next edge
    task automatic step(input bit r, input bit ro, input bit a, input bit d,
                        input bit w, input logic [31:0] adv, input logic [3:0] cv,
                        input bit pin, input string tag);
        exp_t e;
        bit drv, rcv, p;
        @(negedge clk);
        rst = r; role = ro; aph = a; dph = d; wr = w; ad = adv; cbe = cv; par_in = pin;
        drv = ro ? (a || (d && w)) : (!a && d && !w);
        rcv = ro ? (!a && d && !w) : (a || (d && w));
        p   = even_par(adv, cv);
        #1;
        check({tag, (ro ? " R3" : " R4"), " ad_oe"}, ad_oe_o, drv);
        e.tag  = tag;
        e.oe   = !r && drv;
        e.par  = !r && drv && p;
        e.perr = !r && pend_chk && (pend_par != pin);
        q.push_back(e);
        pend_chk = !r && rcv;
        pend_par = p;
        last_par = p;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " R5 par_oe"}, par_oe_o, e.oe);
                check({e.tag, " R2 par"}, par_o, e.par);
                check({e.tag, " R6 perr"}, perr_o, e.perr);
            end
        end
    end

    initial begin
        #(PER*5000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R8 reset with bus activity present
        step(1, 1, 1, 0, 1, 32'hFFFF_0000, 4'h7, 1, "R8 reset");
        step(1, 0, 0, 1, 1, 32'h1234_5678, 4'hF, 0, "R8 reset");
        // R3 initiator address then write data, R1 parity
        step(0, 1, 1, 0, 1, 32'h8000_0001, 4'h7, 0, "R3 init addr R1");
        step(0, 1, 0, 1, 1, 32'hDEAD_BEEF, 4'h0, 0, "R3 init wdata R1");
        step(0, 1, 0, 1, 1, 32'h0000_0001, 4'hE, 1, "R3 init wdata R1");
        // R5 stop driving: idle, bad par ignored R7
        step(0, 1, 0, 0, 0, 32'hFFFF_FFFF, 4'hF, 1, "R5 drop R7");
        step(0, 1, 0, 0, 0, 32'h0, 4'h0, 1, "R7 idle");
        // R6 initiator read: receive, good then bad parity
        step(0, 1, 0, 1, 0, 32'hA5A5_0F0F, 4'h3, 0, "R6 init rd");
        step(0, 1, 0, 1, 0, 32'h0000_0007, 4'h1, last_par, "R6 init rd good");
        step(0, 1, 0, 1, 0, 32'h1111_1111, 4'h8, ~last_par, "R6 init rd bad");
        step(0, 1, 0, 0, 0, 32'h0, 4'h0, ~last_par, "R6 init rd bad2");
        step(0, 1, 0, 0, 0, 32'h0, 4'h0, 1, "R7 after");
        // R4 target read: drives, R9 zero enables
        step(0, 0, 1, 0, 0, 32'h4000_0000, 4'h6, 0, "R4 tgt addr");
        step(0, 0, 0, 1, 0, 32'h0101_0101, 4'h0, last_par, "R4 tgt rd R9");
        step(0, 0, 0, 1, 0, 32'hFF00_0000, 4'h8, 1, "R4 tgt rd R9 lane3");
        step(0, 0, 0, 1, 0, 32'h0000_00FF, 4'h1, 0, "R4 tgt rd R9 lane0");
        // R6 target write: address checked, data checked
        step(0, 0, 1, 0, 1, 32'h0000_0003, 4'h7, 1, "R6 tgt addr");
        step(0, 0, 0, 1, 1, 32'hCAFE_F00D, 4'hF, ~last_par, "R6 tgt addr bad");
        step(0, 0, 0, 1, 1, 32'h7000_0000, 4'h2, last_par, "R6 tgt wr good");
        step(0, 0, 0, 0, 0, 32'h0, 4'h0, ~last_par, "R6 tgt wr bad");
        step(0, 0, 0, 0, 0, 32'h0, 4'h0, 0, "R7 idle tgt");
        // role switch every cycle
        step(0, 1, 0, 1, 1, 32'h0F0F_0F0F, 4'h5, 1, "R5 switch");
        step(0, 0, 0, 1, 1, 32'h3333_3333, 4'hA, 1, "R5 switch");
        step(0, 1, 0, 1, 1, 32'h8888_0000, 4'h1, last_par, "R5 switch");
        step(0, 0, 0, 1, 0, 32'h0000_8888, 4'h4, 1, "R5 switch R7");
        // R8 reset mid checked window
        step(0, 1, 0, 1, 0, 32'h1, 4'h0, 0, "R8 pre");
        step(1, 1, 0, 1, 0, 32'h0, 4'h0, ~last_par, "R8 mid");
        step(0, 1, 0, 0, 0, 32'h0, 4'h0, 1, "R8 post");
        step(0, 1, 0, 0, 0, 32'h0, 4'h0, 0, "R8 post");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule